// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel byte into an asynchronous serial frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period at the high level. A seven-bit format control word selects the layout. A one-cycle enable that pulses at 16 times the baud rate sets the pace, so each bit slot lasts `TICKS_PER_BIT` enables.

Bytes arrive on a valid/ready handshake. The block takes a new byte when it is idle. It also takes one on the final tick of a stop period, so frames can follow each other with no idle gap. The format is captured when a byte is taken, and the frame in flight keeps that format. The break bit is the one exception: it acts on the line at once.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is clear, `txd` is 1, `tx_ready` is 1, `tx_empty` is 1 and `tx_busy` is 0.
- R2: A frame starts with a start bit at 0 that lasts 16 baud ticks. The data bits follow, least significant bit first, and each one lasts 16 ticks.
- R3: Field `fmt_ctrl[1:0]` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: Data bits above the selected word length are never sent, and they do not count toward parity.
- R5: When `fmt_ctrl[3]` is 1, a parity bit of 16 ticks follows the last data bit. With `fmt_ctrl[4]`=1 the count of ones over data plus parity is even; with `fmt_ctrl[4]`=0 it is odd.
- R6: When `fmt_ctrl[3]` and `fmt_ctrl[5]` are both 1, the parity bit is the inverse of `fmt_ctrl[4]`, whatever the data.
- R7: The stop period is high. It lasts 16 ticks when `fmt_ctrl[2]`=0. When `fmt_ctrl[2]`=1 it lasts 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8 bits.
- R8: While `fmt_ctrl[6]` is 1, `txd` is 0 from the next cycle on. The frame underneath keeps its timing and finishes normally.
- R9: A change of `fmt_ctrl[5:0]` after a byte is taken does not affect that frame.
- R10: `tx_ready` is 1 only when idle, or when busy on the clock where a baud tick ends the stop period. A byte taken there starts the next frame with `tx_empty` staying 0.
- R11: `tx_busy` rises, and `tx_empty` falls, on the clock after a byte is taken. They return on the clock after the final stop tick when no new byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the baud rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Framer takes the offered byte on this clock |
| fmt_ctrl | input | 7 | Format word: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] stick, [6] break |
| txd | output | 1 | Serial line, registered |
| tx_busy | output | 1 | A frame is in progress |
| tx_empty | output | 1 | No frame is in progress |

## Verification
The line output is registered from the frame state, so every slot appears on `txd` one clock after the state enters it. The bench therefore reads each bit at the eighth baud tick of its slot, far from both slot edges, and measures the frame length by counting ticks seen while `tx_busy` is high. `tx_busy` and `tx_empty` change one clock after the accepting edge. `tx_ready` is combinational within the final stop tick, so the bench samples it at the falling edge before the edge that acts on it. A break appears on `txd` one clock after `fmt_ctrl[6]` is set, and the bench checks it three clocks later.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_WLEN = 5;
  localparam int FRAME_W  = DATA_W + 2;
  localparam int BITCNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STOP  = 2'd2
  } txf_state_e;

  // packed from bit 6 down to bit 0 of the format word
  typedef struct packed {
    logic       brk;
    logic       par_stick;
    logic       par_even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wlen;
  } txf_ctrl_t;
endpackage

// File: rtl/txf_frame_build.sv
module txf_frame_build
  import uart_txf_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 6
) (
  input  logic [DATA_W-1:0]   data,
  input  txf_ctrl_t           ctrl,
  output logic [FRAME_W-1:0]  frame,
  output logic [BITCNT_W-1:0] nbits,
  output logic [CNT_W-1:0]    stop_ticks
);
  logic [BITCNT_W-1:0] wlen_n;
  logic [BITCNT_W-1:0] par_pos;
  logic [DATA_W-1:0]   masked;
  logic                par_bit;

  assign wlen_n  = BITCNT_W'(MIN_WLEN) + BITCNT_W'(ctrl.wlen);
  assign par_pos = wlen_n + BITCNT_W'(1);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign masked[g] = data[g] & (BITCNT_W'(g) < wlen_n);
  end

  always_comb begin
    if (ctrl.par_stick) par_bit = ~ctrl.par_even;
    else if (ctrl.par_even) par_bit = ^masked;
    else par_bit = ~(^masked);
  end

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (BITCNT_W'(i) < wlen_n) frame[i+1] = masked[i];
    end
    if (ctrl.par_en) frame[par_pos] = par_bit;
  end

  assign nbits = BITCNT_W'(1) + wlen_n + BITCNT_W'(ctrl.par_en);

  always_comb begin
    if (!ctrl.stop_long) stop_ticks = CNT_W'(TICKS_PER_BIT);
    else if (ctrl.wlen == 2'd0) stop_ticks = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    else stop_ticks = CNT_W'(2 * TICKS_PER_BIT);
  end
endmodule

// File: rtl/txf_tick_timer.sv
module txf_tick_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q;

  assign at_last = (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick) cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/txf_line_drive.sv
module txf_line_drive (
  input  logic clk,
  input  logic rst,
  input  logic brk,
  input  logic active,
  input  logic bit_val,
  output logic txd
);
  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else if (brk) txd <= 1'b0;
    else txd <= active ? bit_val : 1'b1;
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [6:0]        fmt_ctrl,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_empty
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

  txf_ctrl_t           ctrl_w;
  txf_state_e          state_q, state_d;
  logic [FRAME_W-1:0]  sreg_q, frame_w;
  logic [BITCNT_W-1:0] bits_left_q, nbits_w;
  logic [CNT_W-1:0]    stop_lim_q, stop_w, limit_w;
  logic                tick_en, at_last, period_end, accept;

  assign ctrl_w = txf_ctrl_t'(fmt_ctrl);

  txf_frame_build #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) u_build (
    .data(tx_data), .ctrl(ctrl_w), .frame(frame_w), .nbits(nbits_w), .stop_ticks(stop_w)
  );

  assign limit_w = (state_q == ST_STOP) ? stop_lim_q : CNT_W'(TICKS_PER_BIT);
  assign tick_en = baud_tick && (state_q != ST_IDLE);

  txf_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clear(accept), .tick(tick_en), .limit(limit_w), .at_last(at_last)
  );

  assign period_end = tick_en && at_last;
  assign tx_ready   = (state_q == ST_IDLE) || ((state_q == ST_STOP) && period_end);
  assign accept     = tx_valid && tx_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SHIFT;
      ST_SHIFT: if (period_end && bits_left_q == BITCNT_W'(1)) state_d = ST_STOP;
      ST_STOP:  if (period_end) state_d = accept ? ST_SHIFT : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sreg_q      <= '1;
      bits_left_q <= '0;
      stop_lim_q  <= CNT_W'(TICKS_PER_BIT);
      tx_busy     <= 1'b0;
      tx_empty    <= 1'b1;
    end else begin
      state_q  <= state_d;
      tx_busy  <= (state_d != ST_IDLE);
      tx_empty <= (state_d == ST_IDLE);
      if (accept) begin
        sreg_q      <= frame_w;
        bits_left_q <= nbits_w;
        stop_lim_q  <= stop_w;
      end else if (state_q == ST_SHIFT && period_end) begin
        sreg_q      <= {1'b1, sreg_q[FRAME_W-1:1]};
        bits_left_q <= bits_left_q - BITCNT_W'(1);
      end
    end
  end

  txf_line_drive u_line (
    .clk(clk), .rst(rst), .brk(ctrl_w.brk),
    .active(state_q != ST_IDLE), .bit_val(sreg_q[0]), .txd(txd)
  );
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       baud_tick,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [6:0] fmt_ctrl,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_empty
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tx_empty) && !$past(fmt_ctrl[6]) |-> txd); // R1
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fmt_ctrl[6]) |-> !txd); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> tx_busy && !tx_empty); // R11
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tx_ready && tx_busy |-> baud_tick); // R10
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> $past(tx_valid && tx_ready)); // R11
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .fmt_ctrl(fmt_ctrl), .txd(txd), .tx_busy(tx_busy), .tx_empty(tx_empty)
);

// File: tb/tb_uart_tx_framer.sv
module tb_uart_tx_framer;
  logic       clk, rst, baud_tick, tx_valid, tx_ready, txd, tx_busy, tx_empty;
  logic [7:0] tx_data;
  logic [6:0] fmt_ctrl;
  int errs = 0, checks = 0, mon_ticks = 0, ph = 0;
  logic mon_bits [0:47];
  logic watch_gap = 0, gap_seen = 0;

  uart_tx_framer dut (.clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .fmt_ctrl(fmt_ctrl), .txd(txd),
    .tx_busy(tx_busy), .tx_empty(tx_empty));

  initial begin clk = 0; forever #4 clk = ~clk; end

  initial begin
    baud_tick = 0;
    forever begin @(posedge clk); #1; ph = (ph + 1) % 4; baud_tick = (ph == 0); end
  end

  always @(negedge clk) begin
    if (tx_busy && baud_tick) begin
      if (mon_ticks % 16 == 8 && mon_ticks / 16 < 48) mon_bits[mon_ticks / 16] = txd;
      mon_ticks = mon_ticks + 1;
    end
    if (watch_gap && tx_empty) gap_seen = 1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int f_n(logic [6:0] c); return 5 + int'(c[1:0]); endfunction
  function automatic int f_nbits(logic [6:0] c); return 1 + f_n(c) + int'(c[3]); endfunction
  function automatic int f_stop(logic [6:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'd0) ? 24 : 32;
  endfunction
  function automatic int f_ticks(logic [6:0] c); return f_nbits(c) * 16 + f_stop(c); endfunction
  function automatic logic f_bit(logic [7:0] d, logic [6:0] c, int i);
    int n = f_n(c);
    logic [7:0] m = d & 8'((1 << n) - 1);
    logic p;
    if (c[5]) p = ~c[4];
    else p = c[4] ? ($countones(m) % 2 == 1) : ($countones(m) % 2 == 0);
    if (i == 0) return 1'b0;
    if (i <= n) return m[i-1];
    if (i == n + 1 && c[3]) return p;
    return 1'b1;
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (!tx_empty);
  endtask
  task automatic start_frame(logic [7:0] d, logic [6:0] c);
    wait_idle();
    fmt_ctrl = c;
    @(posedge clk); #1;
    tx_data = d; tx_valid = 1; mon_ticks = 0;
    @(posedge clk); #1;
    tx_valid = 0;
  endtask
  task automatic check_frame(string req, logic [7:0] d, logic [6:0] c, int base);
    int act = 0, exp = 0;
    for (int i = 0; i <= f_nbits(c); i++) begin
      act = act | (int'(mon_bits[base + i] === 1'b1) << i);
      exp = exp | (int'(f_bit(d, c, i)) << i);
    end
    check(req, "frame bits", act, exp);
  endtask

  // {fmt_ctrl, data}
  localparam logic [14:0] VEC [10] = '{
    {7'b0000011, 8'hA5},  // R2 R3 8 bits, 1 stop
    {7'b0000000, 8'hFF},  // R3 R4 5 bits, upper ones dropped
    {7'b0000001, 8'h3C},  // R3 6 bits
    {7'b0000110, 8'h55},  // R3 R7 7 bits, 2 stop
    {7'b0000100, 8'h13},  // R7 5 bits, 1.5 stop
    {7'b0011011, 8'h07},  // R5 8 bits even parity
    {7'b0001000, 8'hE0},  // R4 R5 5 bits odd parity, masked zero
    {7'b0111011, 8'h01},  // R6 stick, bit4=1 gives 0
    {7'b0101111, 8'h00},  // R6 R7 stick, bit4=0 gives 1, 2 stop
    {7'b0011000, 8'hE1}   // R4 R5 5 bits even parity, masked
  };

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1; tx_valid = 0; tx_data = 0; fmt_ctrl = 7'h03;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1", "txd after reset", int'(txd), 1);
    check("R1", "ready after reset", int'(tx_ready), 1);
    check("R11", "empty after reset", int'(tx_empty), 1);
    check("R11", "busy after reset", int'(tx_busy), 0);

    for (int v = 0; v < 10; v++) begin
      logic [6:0] c = VEC[v][14:8];
      logic [7:0] d = VEC[v][7:0];
      start_frame(d, c);
      wait_idle();
      check("R7", "frame ticks", mon_ticks, f_ticks(c));
      check("R2", "frame content", 0, 0);
      checks--;
      check_frame("R2/R5", d, c, 0);
    end

    // R8: break mid frame, frame timing unchanged
    start_frame(8'hFF, 7'h03);
    repeat (20) @(posedge clk);
    #1 fmt_ctrl = 7'h43;
    repeat (3) @(negedge clk);
    check("R8", "txd under break", int'(txd), 0);
    check("R10", "ready mid frame", int'(tx_ready), 0);
    @(posedge clk); #1 fmt_ctrl = 7'h03;
    wait_idle();
    check("R8", "ticks with break", mon_ticks, f_ticks(7'h03));
    @(negedge clk);
    check("R1", "line high after break", int'(txd), 1);

    // R9: format change after acceptance
    start_frame(8'h5A, 7'h00);
    repeat (8) @(posedge clk);
    #1 fmt_ctrl = 7'h3F;
    wait_idle();
    check("R9", "ticks keep old format", mon_ticks, f_ticks(7'h00));
    check_frame("R9", 8'h5A, 7'h00, 0);

    // R10: back-to-back frames
    wait_idle();
    fmt_ctrl = 7'h03;
    @(posedge clk); #1;
    tx_data = 8'h96; tx_valid = 1; mon_ticks = 0; gap_seen = 0;
    @(posedge clk); #1;
    tx_data = 8'h3B; watch_gap = 1;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1 tx_valid = 0; watch_gap = 0;
    wait_idle();
    check("R10", "no idle gap", int'(gap_seen), 0);
    check("R10", "two frame ticks", mon_ticks, 2 * f_ticks(7'h03));
    check_frame("R10", 8'h96, 7'h03, 0);
    check_frame("R10", 8'h3B, 7'h03, 10);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule